// File: doc/BRIEF.md
# Latched Accumulator Arithmetic Unit

This block is the arithmetic datapath of a small single-address processor. Two operand registers, a first operand latch and a second operand latch, feed a combinational arithmetic stage at all times. Neither operand latch is ever driven back out of the block. The arithmetic result has one destination only, the accumulator register, and the accumulator's top bit is brought out as a sign flag for a branch-if-not-negative decision elsewhere.

A sequencer outside the block places the memory operand in the first latch and copies the previous accumulator value into the second latch. In a later cycle it raises exactly one operation enable together with the accumulator write enable. The one-operand operations (pass-through, ones' complement, shift left, arithmetic shift right) use only the first latch. Addition sums both latches, which means memory operand plus prior accumulator.

The block has no state machine. Its only sequential state is three registers: two operand latches and the accumulator. All three clear on an active-low reset.

Top module: `latched_alu_acc`

## Requirements
- R1: While `rst_n` is low, and after it is released, both operand latches and the accumulator read zero, so `acc_q` is 0 and `acc_sign` is 0.
- R2: An operand latch takes its data input on a rising clock edge where its write enable is high. Otherwise it keeps its value.
- R3: With `op_en` = 5'b00001 (bit 0, load) and `acc_we` high, the accumulator takes the first latch unchanged.
- R4: With `op_en` = 5'b00010 (bit 1, add) and `acc_we` high, the accumulator takes the sum of the two latches modulo 2^W. The carry out is dropped.
- R5: With `op_en` = 5'b00100 (bit 2, complement) and `acc_we` high, the accumulator takes the bitwise inverse of the first latch. This is ones' complement, not negation.
- R6: With `op_en` = 5'b01000 (bit 3, shift left) and `acc_we` high, the accumulator takes the first latch shifted left by one, with bit 0 set to 0.
- R7: With `op_en` = 5'b10000 (bit 4, shift right) and `acc_we` high, the accumulator takes the first latch shifted right by one, with the top bit copied from the operand's sign.
- R8: The accumulator keeps its value unless `acc_we` is high and exactly one bit of `op_en` is set. This covers no enable set, two or more set, and `acc_we` low.
- R9: `acc_sign` always equals the most significant bit of `acc_q`.
- R10: When a latch is written in the same cycle as an accumulator update, the arithmetic uses the latch contents from before that clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| lat1_we | input | 1 | First operand latch write enable |
| lat1_d | input | W | First operand latch data (memory operand) |
| lat2_we | input | 1 | Second operand latch write enable |
| lat2_d | input | W | Second operand latch data (prior accumulator) |
| op_en | input | 5 | One-hot operation enables: bit0 load, bit1 add, bit2 complement, bit3 shift left, bit4 shift right |
| acc_we | input | 1 | Accumulator write enable |
| acc_q | output | W | Accumulator value |
| acc_sign | output | 1 | Accumulator sign bit |

## Verification
On every cycle the assertions check the following: the accumulator matches each operation's result computed from the latch contents one cycle earlier, the accumulator and both latches hold whenever their write conditions are absent, and the sign flag tracks the top bit. The same-cycle interaction between a latch write and an accumulator update is shown only by the bench's directed scenarios. So are the specific boundary values: carry-out loss, sign fill on shift right, and zero fill on shift left. A random sequence of writes and operations is compared against a bench model.

// File: rtl/latalu_pkg.sv
package latalu_pkg;

    localparam int NUM_OPS = 5;

    // one-hot operation selector, bit positions are part of the port contract
    typedef enum logic [NUM_OPS-1:0] {
        OP_LOAD  = 5'b00001,
        OP_ADD   = 5'b00010,
        OP_CPL   = 5'b00100,
        OP_SHL   = 5'b01000,
        OP_SHR   = 5'b10000
    } op_sel_e;

endpackage

// File: rtl/latalu_latch.sv
module latalu_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= d;
        end
    end

endmodule

// File: rtl/latalu_core.sv
module latalu_core
    import latalu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]       opa,
    input  logic [W-1:0]       opb,
    input  logic [NUM_OPS-1:0] op_en,
    output logic [W-1:0]       result,
    output logic               valid
);

    localparam int MSB = W - 1;

    logic [W-1:0] sum_w;
    logic [W-1:0] shl_w;
    logic [W-1:0] shr_w;

    // carry out is dropped by the truncating assignment
    assign sum_w = opa + opb;
    assign shl_w = {opa[MSB-1:0], 1'b0};
    assign shr_w = {opa[MSB], opa[MSB:1]};

    always_comb begin
        result = opa;
        valid  = 1'b1;
        case (op_en)
            OP_LOAD: result = opa;
            OP_ADD:  result = sum_w;
            OP_CPL:  result = ~opa;
            OP_SHL:  result = shl_w;
            OP_SHR:  result = shr_w;
            default: begin
                result = opa;
                valid  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/latalu_acc.sv
module latalu_acc #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic         valid,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we && valid) begin
            q <= d;
        end
    end

endmodule

// File: rtl/latched_alu_acc.sv
module latched_alu_acc
    import latalu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lat1_we,
    input  logic [W-1:0]       lat1_d,
    input  logic               lat2_we,
    input  logic [W-1:0]       lat2_d,
    input  logic [NUM_OPS-1:0] op_en,
    input  logic               acc_we,
    output logic [W-1:0]       acc_q,
    output logic               acc_sign
);

    localparam int NUM_LAT = 2;

    logic [NUM_LAT-1:0]        lat_we;
    logic [NUM_LAT-1:0][W-1:0] lat_d;
    logic [NUM_LAT-1:0][W-1:0] lat_q;
    logic [W-1:0]              alu_res;
    logic                      alu_ok;

    assign lat_we = {lat2_we, lat1_we};
    assign lat_d  = {lat2_d, lat1_d};

    generate
        for (genvar i = 0; i < NUM_LAT; i++) begin : g_lat
            latalu_latch #(.W(W)) u_lat (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (lat_we[i]),
                .d     (lat_d[i]),
                .q     (lat_q[i])
            );
        end
    endgenerate

    latalu_core #(.W(W)) u_core (
        .opa    (lat_q[0]),
        .opb    (lat_q[1]),
        .op_en  (op_en),
        .result (alu_res),
        .valid  (alu_ok)
    );

    latalu_acc #(.W(W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (acc_we),
        .valid (alu_ok),
        .d     (alu_res),
        .q     (acc_q)
    );

    assign acc_sign = acc_q[W-1];

endmodule

// File: rtl/latched_alu_acc_chk.sv
module latched_alu_acc_chk
    import latalu_pkg::*;
#(
    parameter int W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lat1_we,
    input logic               lat2_we,
    input logic [NUM_OPS-1:0] op_en,
    input logic               acc_we,
    input logic [W-1:0]       acc_q,
    input logic               acc_sign,
    input logic [W-1:0]       l1,
    input logic [W-1:0]       l2
);

    // R3
    load_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && op_en == 5'b00001) |=> acc_q == $past(l1));

    // R4
    add_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && op_en == 5'b00010) |=> acc_q == W'($past(l1) + $past(l2)));

    // R5
    cpl_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && op_en == 5'b00100) |=> acc_q == ~$past(l1));

    // R6
    shl_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && op_en == 5'b01000) |=> acc_q == {$past(l1[W-2:0]), 1'b0});

    // R7
    shr_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && op_en == 5'b10000) |=> acc_q == {$past(l1[W-1]), $past(l1[W-1:1])});

    // R8
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_we && $countones(op_en) == 1) |=> $stable(acc_q));

    // R2
    lat1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lat1_we |=> $stable(l1));

    // R2
    lat2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lat2_we |=> $stable(l2));

    // R9
    sign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc_q[W-1]) == $past(acc_sign));

endmodule

bind latched_alu_acc latched_alu_acc_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lat1_we  (lat1_we),
    .lat2_we  (lat2_we),
    .op_en    (op_en),
    .acc_we   (acc_we),
    .acc_q    (acc_q),
    .acc_sign (acc_sign),
    .l1       (lat_q[0]),
    .l2       (lat_q[1])
);

// File: tb/latched_alu_acc_test.sv
module latched_alu_acc_test;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         lat1_we = 1'b0;
    logic [W-1:0] lat1_d = '0;
    logic         lat2_we = 1'b0;
    logic [W-1:0] lat2_d = '0;
    logic [4:0]   op_en = '0;
    logic         acc_we = 1'b0;
    logic [W-1:0] acc_q;
    logic         acc_sign;

    int checks = 0;
    int errors = 0;

    logic [W-1:0] m_l1 = '0;
    logic [W-1:0] m_l2 = '0;
    logic [W-1:0] m_acc = '0;

    always #4 clk = ~clk;

    latched_alu_acc #(.W(W)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .lat1_we  (lat1_we),
        .lat1_d   (lat1_d),
        .lat2_we  (lat2_we),
        .lat2_d   (lat2_d),
        .op_en    (op_en),
        .acc_we   (acc_we),
        .acc_q    (acc_q),
        .acc_sign (acc_sign)
    );

    function automatic logic [W-1:0] ref_next(input logic [4:0] op, input logic we,
                                             input logic [W-1:0] a, input logic [W-1:0] b,
                                             input logic [W-1:0] cur);
        if (!we) return cur;
        case (op)
            5'b00001: return a;
            5'b00010: return W'(a + b);
            5'b00100: return ~a;
            5'b01000: return {a[W-2:0], 1'b0};
            5'b10000: return {a[W-1], a[W-1:1]};
            default:  return cur;
        endcase
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // drive at negedge, advance one edge, sample at the following negedge
    task automatic step(input logic w1, input logic [W-1:0] d1, input logic w2,
                        input logic [W-1:0] d2, input logic [4:0] op, input logic aw,
                        input string tag);
        lat1_we = w1; lat1_d = d1; lat2_we = w2; lat2_d = d2; op_en = op; acc_we = aw;
        m_acc = ref_next(op, aw, m_l1, m_l2, m_acc);
        if (w1) m_l1 = d1;
        if (w2) m_l2 = d2;
        @(posedge clk);
        @(negedge clk);
        check(tag, acc_q, m_acc);
        check("R9 sign", {7'd0, acc_sign}, {7'd0, m_acc[W-1]});
    endtask

    task automatic setl(input logic [W-1:0] a, input logic [W-1:0] b);
        step(1'b1, a, 1'b1, b, 5'b00000, 1'b0, "R2 latch write, acc idle");
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        check("R1 reset acc", acc_q, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 acc after release", acc_q, 8'h00);
        step(1'b0, 8'h00, 1'b0, 8'h00, 5'b00001, 1'b1, "R1 latch reset value via load");

        setl(8'h5A, 8'h00);
        step(1'b0, 8'h00, 1'b0, 8'h00, 5'b00001, 1'b1, "R3 load");
        setl(8'hC8, 8'h64);
        step(1'b0, 8'h00, 1'b0, 8'h00, 5'b00010, 1'b1, "R4 add wraps 200+100");
        setl(8'h55, 8'h00);
        step(1'b0, 8'h00, 1'b0, 8'h00, 5'b00100, 1'b1, "R5 complement");
        setl(8'h81, 8'h00);
        step(1'b0, 8'h00, 1'b0, 8'h00, 5'b01000, 1'b1, "R6 shift left zero fill");
        setl(8'h80, 8'h00);
        step(1'b0, 8'h00, 1'b0, 8'h00, 5'b10000, 1'b1, "R7 shift right sign fill");
        setl(8'h41, 8'h00);
        step(1'b0, 8'h00, 1'b0, 8'h00, 5'b10000, 1'b1, "R7 shift right positive");

        setl(8'h33, 8'h11);
        step(1'b0, 8'h00, 1'b0, 8'h00, 5'b00000, 1'b1, "R8 no enable holds");
        step(1'b0, 8'h00, 1'b0, 8'h00, 5'b00011, 1'b1, "R8 two enables hold");
        step(1'b0, 8'h00, 1'b0, 8'h00, 5'b00010, 1'b0, "R8 acc_we low holds");
        step(1'b0, 8'h00, 1'b0, 8'h00, 5'b00001, 1'b1, "R2 latch kept value");

        step(1'b1, 8'h99, 1'b1, 8'h01, 5'b00010, 1'b1, "R10 add uses old latches");
        step(1'b0, 8'h00, 1'b0, 8'h00, 5'b00010, 1'b1, "R10 add uses new latches");

        for (int i = 0; i < 400; i++) begin
            logic [4:0] op;
            int sel;
            sel = int'($urandom_range(0, 6));
            if (sel < 5) op = 5'(1 << sel);
            else if (sel == 5) op = 5'b00000;
            else op = 5'($urandom_range(0, 31));
            step(1'($urandom_range(0, 1)), 8'($urandom), 1'($urandom_range(0, 1)),
                 8'($urandom), op, 1'($urandom_range(0, 3) != 0), "R8 random sequence");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule